// File: doc/BRIEF.md
# Bus-Mapped FIFO Access Port

This block is an AHB-Lite slave that puts an external FIFO on a 32-bit system bus. A single word address at the start of its window acts as the data port. A write transfer to that address pushes the write data into the FIFO. A read transfer pops the oldest word and returns it. The FIFO storage is not part of this block. The block drives the push and pop strobes and takes back the FIFO's read data, its level flags and its two occupancy counts.

Above the data port, a small bank of word registers serves several purposes:
- it holds the six programmable level thresholds that the FIFO needs;
- it issues pointer flush pulses;
- it holds the interrupt enables;
- it exposes the live flags and both counts;
- it keeps a sticky interrupt record that is cleared when software reads it.

A single interrupt line follows the live flags through a per-source mask and a global gate. Write transfers finish without a wait state. Every read transfer stretches its data phase by one cycle. This gives the FIFO one cycle to deliver the popped word, and gives the interrupt record its clear-on-read timing.

Top module: `fifo_bus_bridge`

## Requirements
- R1: The block responds only to transfers with hsel=1 and htrans[1]=1 whose haddr[31:6] equals BASE_ADDR[31:6]. BASE_ADDR must sit on a 1 KB boundary. Any other transfer, and any IDLE or BUSY cycle, causes no FIFO strobe, no register change and no wait state.
- R2: A read of offset 0x00 raises pop_en for one cycle, provided the FIFO is not empty. On the completing cycle, hrdata carries pop_data, zero-extended to 32 bits. A read of offset 0x00 while empty raises no pop_en and returns 0.
- R3: A read transfer drives hreadyout low for exactly the first cycle of its data phase. A write transfer keeps hreadyout high. hresp is always 0 (OKAY).
- R4: A write to offset 0x00 raises push_en for the data-phase cycle, with push_data = hwdata[DW-1:0]. When st_full=1, no push_en is raised.
- R5: The threshold registers are read/write, and each drives its own output:
  - 0x04 pfull_lvl (WCW bits)
  - 0x08 pempty_lvl (RCW bits)
  - 0x0C pfull_hi (WCW bits)
  - 0x10 pempty_lo (RCW bits)
  - 0x14 pfull_lo (WCW bits)
  - 0x18 pempty_hi (RCW bits)

  A write keeps only the low bits of each register. A read returns the value zero-extended.
- R6: The control register at 0x1C uses four bits:
  - bit 0 is the global interrupt enable, which is read/write;
  - writing 1 to bit 1, 2 or 3 gives a one-cycle pulse on flush_rd, flush_wr or flush_all, starting the cycle after the data phase;
  - bits 1 to 3 read back as 0.
- R7: The flag vector is {pempty, pfull, aempty, afull, empty, full}, from bit 5 down to bit 0. It is read live at 0x24. The 6-bit interrupt enable at 0x20 is read/write in the same bit order. The write-side count is read at 0x28 and the read-side count at 0x2C.
- R8: irq = global enable AND (OR over the six bits of flags AND enables).
- R9: Bit n of the interrupt record at 0x30 sets whenever flag n and enable n are both 1. A read of 0x30 returns the record, then clears it to 0. A source still active after the read sets its bit again.
- R10: Offsets 0x34 to 0x3C read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (all accesses treated as words) |
| hwdata | input | 32 | Write data |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Transfer done |
| hresp | output | 1 | Response, always OKAY |
| push_en | output | 1 | FIFO push strobe |
| push_data | output | DW | Word to push |
| pop_en | output | 1 | FIFO pop strobe |
| pop_data | input | DW | Word from the FIFO, valid the cycle after pop_en |
| st_full | input | 1 | FIFO full |
| st_empty | input | 1 | FIFO empty |
| st_afull | input | 1 | One free slot left |
| st_aempty | input | 1 | One word left |
| st_pfull | input | 1 | Programmable full |
| st_pempty | input | 1 | Programmable empty |
| occ_wr | input | WCW | Occupancy, write side |
| occ_rd | input | RCW | Occupancy, read side |
| flush_all | output | 1 | Flush both pointers (pulse) |
| flush_wr | output | 1 | Flush write pointer (pulse) |
| flush_rd | output | 1 | Flush read pointer (pulse) |
| pfull_lvl | output | WCW | Programmable full threshold |
| pempty_lvl | output | RCW | Programmable empty threshold |
| pfull_hi | output | WCW | Programmable full assert level |
| pempty_lo | output | RCW | Programmable empty assert level |
| pfull_lo | output | WCW | Programmable full release level |
| pempty_hi | output | RCW | Programmable empty release level |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- the handshake shape: an accepted read is followed by exactly one low cycle of hreadyout, and an accepted write by none;
- each flush pulse traces back to a control write in the previous cycle;
- a read of the interrupt record leaves it at zero when no enabled source is active.

Other behaviour is shown only by the bench scenarios:
- data ordering through the FIFO and the zero returned by a pop while empty;
- the blocked push while full;
- threshold truncation and zero-extension;
- the masking of irq by the global and per-source enables;
- the silence of out-of-window and unused offsets.

// File: rtl/fbb_pkg.sv
package fbb_pkg;

   localparam int NSRC = 6;

   // word index = haddr[5:2]; software depends on this order
   typedef enum logic [3:0] {
      RIX_DATA   = 4'd0,
      RIX_PF_LVL = 4'd1,
      RIX_PE_LVL = 4'd2,
      RIX_PF_HI  = 4'd3,
      RIX_PE_LO  = 4'd4,
      RIX_PF_LO  = 4'd5,
      RIX_PE_HI  = 4'd6,
      RIX_CTRL   = 4'd7,
      RIX_IE     = 4'd8,
      RIX_STAT   = 4'd9,
      RIX_WCNT   = 4'd10,
      RIX_RCNT   = 4'd11,
      RIX_ISTAT  = 4'd12
   } reg_idx_e;

   // control register bit positions
   localparam int CTL_GIE       = 0;
   localparam int CTL_FLUSH_RD  = 1;
   localparam int CTL_FLUSH_WR  = 2;
   localparam int CTL_FLUSH_ALL = 3;

endpackage

// File: rtl/fbb_bus_port.sv
module fbb_bus_port
   import fbb_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR = 32'hA000_0400,
   parameter int          DW        = 32
) (
   input  logic          hclk,
   input  logic          hresetn,
   input  logic          hsel,
   input  logic [31:0]   haddr,
   input  logic [1:0]    htrans,
   input  logic          hwrite,
   input  logic [2:0]    hsize,
   input  logic [31:0]   hwdata,
   output logic [31:0]   hrdata,
   output logic          hreadyout,
   output logic          hresp,
   output logic          push_en,
   output logic [DW-1:0] push_data,
   output logic          pop_en,
   input  logic [DW-1:0] pop_data,
   input  logic          st_full,
   input  logic          st_empty,
   output logic [3:0]    reg_idx,
   output logic          reg_wr,
   output logic          reg_rd,
   input  logic [31:0]   reg_rdata
);

   localparam int WIN_LSB = 6;

   if (BASE_ADDR[9:0] != 10'd0) begin : g_bad_base
      $error("BASE_ADDR must be 1 KB aligned");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("DW must lie in 1..32");
   end

   logic       acc;
   logic       dp_act, dp_wr, rd_late;
   logic [3:0] dp_idx;
   logic       wait_cyc;
   logic       pop_sel_q, pop_ok_q;
   logic [31:0] rd_val_q;
   logic       unused_bits;

   assign unused_bits = ^{hsize, haddr[1:0], htrans[0]};

   assign acc = hsel && htrans[1] && hreadyout &&
                (haddr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]);

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dp_act <= 1'b0;
         dp_wr  <= 1'b0;
         dp_idx <= '0;
      end else if (acc) begin
         dp_act <= 1'b1;
         dp_wr  <= hwrite;
         dp_idx <= haddr[5:2];
      end else if (hreadyout) begin
         dp_act <= 1'b0;
      end
   end

   assign wait_cyc  = dp_act && !dp_wr && !rd_late;
   assign hreadyout = !wait_cyc;
   assign hresp     = 1'b0;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         rd_late   <= 1'b0;
         pop_sel_q <= 1'b0;
         pop_ok_q  <= 1'b0;
         rd_val_q  <= '0;
      end else begin
         rd_late <= wait_cyc;
         if (wait_cyc) begin
            pop_sel_q <= (dp_idx == RIX_DATA);
            pop_ok_q  <= pop_en;
            rd_val_q  <= reg_rdata;
         end
      end
   end

   assign push_en   = dp_act && dp_wr && (dp_idx == RIX_DATA) && !st_full;
   assign push_data = hwdata[DW-1:0];
   assign pop_en    = wait_cyc && (dp_idx == RIX_DATA) && !st_empty;

   assign reg_idx = dp_idx;
   assign reg_wr  = dp_act && dp_wr;
   assign reg_rd  = wait_cyc;

   if (DW < 32) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^hwdata[31:DW];
   end

   always_comb begin
      hrdata = '0;
      if (rd_late) begin
         if (pop_sel_q) hrdata = pop_ok_q ? 32'(pop_data) : 32'd0;
         else           hrdata = rd_val_q;
      end
   end

   p_rd_wait_r3: assert property (@(posedge hclk) disable iff (!hresetn)
      (acc && !hwrite) |=> !hreadyout);
   p_wr_nowait_r3: assert property (@(posedge hclk) disable iff (!hresetn)
      (acc && hwrite) |=> hreadyout);
   p_one_wait_r3: assert property (@(posedge hclk) disable iff (!hresetn)
      !hreadyout |=> hreadyout);

endmodule

// File: rtl/fbb_regs.sv
module fbb_regs
   import fbb_pkg::*;
#(
   parameter int WCW = 9,
   parameter int RCW = 9
) (
   input  logic            hclk,
   input  logic            hresetn,
   input  logic [3:0]      reg_idx,
   input  logic            reg_wr,
   input  logic [31:0]     reg_wdata,
   input  logic            reg_rd,
   output logic [31:0]     reg_rdata,
   input  logic [NSRC-1:0] status,
   input  logic [WCW-1:0]  occ_wr,
   input  logic [RCW-1:0]  occ_rd,
   output logic [WCW-1:0]  pfull_lvl,
   output logic [RCW-1:0]  pempty_lvl,
   output logic [WCW-1:0]  pfull_hi,
   output logic [RCW-1:0]  pempty_lo,
   output logic [WCW-1:0]  pfull_lo,
   output logic [RCW-1:0]  pempty_hi,
   output logic            flush_all,
   output logic            flush_wr,
   output logic            flush_rd,
   output logic            irq
);

   if (WCW < 4 || WCW > 19) begin : g_bad_wcw
      $error("WCW must lie in 4..19");
   end
   if (RCW < 4 || RCW > 19) begin : g_bad_rcw
      $error("RCW must lie in 4..19");
   end

   logic            gie;
   logic [NSRC-1:0] ie, istat, hits;
   logic            unused_wd;

   assign unused_wd = ^reg_wdata;
   assign hits      = status & ie;

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         pfull_lvl  <= '0;
         pempty_lvl <= '0;
         pfull_hi   <= '0;
         pempty_lo  <= '0;
         pfull_lo   <= '0;
         pempty_hi  <= '0;
         gie        <= 1'b0;
         ie         <= '0;
         flush_all  <= 1'b0;
         flush_wr   <= 1'b0;
         flush_rd   <= 1'b0;
      end else begin
         flush_all <= 1'b0;
         flush_wr  <= 1'b0;
         flush_rd  <= 1'b0;
         if (reg_wr) begin
            case (reg_idx)
               RIX_PF_LVL: pfull_lvl  <= reg_wdata[WCW-1:0];
               RIX_PE_LVL: pempty_lvl <= reg_wdata[RCW-1:0];
               RIX_PF_HI:  pfull_hi   <= reg_wdata[WCW-1:0];
               RIX_PE_LO:  pempty_lo  <= reg_wdata[RCW-1:0];
               RIX_PF_LO:  pfull_lo   <= reg_wdata[WCW-1:0];
               RIX_PE_HI:  pempty_hi  <= reg_wdata[RCW-1:0];
               RIX_CTRL: begin
                  gie       <= reg_wdata[CTL_GIE];
                  flush_rd  <= reg_wdata[CTL_FLUSH_RD];
                  flush_wr  <= reg_wdata[CTL_FLUSH_WR];
                  flush_all <= reg_wdata[CTL_FLUSH_ALL];
               end
               RIX_IE:  ie <= reg_wdata[NSRC-1:0];
               default: ;
            endcase
         end
      end
   end

   // sticky record: a new hit wins over the read clear
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn)
         istat <= '0;
      else if (reg_rd && reg_idx == RIX_ISTAT)
         istat <= hits;
      else
         istat <= istat | hits;
   end

   always_comb begin
      case (reg_idx)
         RIX_PF_LVL: reg_rdata = 32'(pfull_lvl);
         RIX_PE_LVL: reg_rdata = 32'(pempty_lvl);
         RIX_PF_HI:  reg_rdata = 32'(pfull_hi);
         RIX_PE_LO:  reg_rdata = 32'(pempty_lo);
         RIX_PF_LO:  reg_rdata = 32'(pfull_lo);
         RIX_PE_HI:  reg_rdata = 32'(pempty_hi);
         RIX_CTRL:   reg_rdata = 32'(gie);
         RIX_IE:     reg_rdata = 32'(ie);
         RIX_STAT:   reg_rdata = 32'(status);
         RIX_WCNT:   reg_rdata = 32'(occ_wr);
         RIX_RCNT:   reg_rdata = 32'(occ_rd);
         RIX_ISTAT:  reg_rdata = 32'(istat);
         default:    reg_rdata = 32'd0;
      endcase
   end

   assign irq = gie && (|hits);

   p_istat_clr_r9: assert property (@(posedge hclk) disable iff (!hresetn)
      (reg_rd && reg_idx == RIX_ISTAT && hits == '0) |=> (istat == '0));
   p_flush_src_r6: assert property (@(posedge hclk) disable iff (!hresetn)
      (flush_wr || flush_rd || flush_all) |-> $past(reg_wr && reg_idx == RIX_CTRL));

endmodule

// File: rtl/fifo_bus_bridge.sv
module fifo_bus_bridge
   import fbb_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR = 32'hA000_0400,
   parameter int          DW        = 32,
   parameter int          WCW       = 9,
   parameter int          RCW       = 9
) (
   input  logic           hclk,
   input  logic           hresetn,
   input  logic           hsel,
   input  logic [31:0]    haddr,
   input  logic [1:0]     htrans,
   input  logic           hwrite,
   input  logic [2:0]     hsize,
   input  logic [31:0]    hwdata,
   output logic [31:0]    hrdata,
   output logic           hreadyout,
   output logic           hresp,
   output logic           push_en,
   output logic [DW-1:0]  push_data,
   output logic           pop_en,
   input  logic [DW-1:0]  pop_data,
   input  logic           st_full,
   input  logic           st_empty,
   input  logic           st_afull,
   input  logic           st_aempty,
   input  logic           st_pfull,
   input  logic           st_pempty,
   input  logic [WCW-1:0] occ_wr,
   input  logic [RCW-1:0] occ_rd,
   output logic           flush_all,
   output logic           flush_wr,
   output logic           flush_rd,
   output logic [WCW-1:0] pfull_lvl,
   output logic [RCW-1:0] pempty_lvl,
   output logic [WCW-1:0] pfull_hi,
   output logic [RCW-1:0] pempty_lo,
   output logic [WCW-1:0] pfull_lo,
   output logic [RCW-1:0] pempty_hi,
   output logic           irq
);

   logic [3:0]      reg_idx;
   logic            reg_wr, reg_rd;
   logic [31:0]     reg_rdata;
   logic [NSRC-1:0] status;

   assign status = {st_pempty, st_pfull, st_aempty, st_afull, st_empty, st_full};

   fbb_bus_port #(.BASE_ADDR(BASE_ADDR), .DW(DW)) u_port (
      .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
      .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
      .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
      .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
      .pop_data(pop_data), .st_full(st_full), .st_empty(st_empty),
      .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   fbb_regs #(.WCW(WCW), .RCW(RCW)) u_regs (
      .hclk(hclk), .hresetn(hresetn), .reg_idx(reg_idx), .reg_wr(reg_wr),
      .reg_wdata(hwdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .status(status), .occ_wr(occ_wr), .occ_rd(occ_rd),
      .pfull_lvl(pfull_lvl), .pempty_lvl(pempty_lvl), .pfull_hi(pfull_hi),
      .pempty_lo(pempty_lo), .pfull_lo(pfull_lo), .pempty_hi(pempty_hi),
      .flush_all(flush_all), .flush_wr(flush_wr), .flush_rd(flush_rd),
      .irq(irq)
   );

endmodule

// File: tb/fifo_bus_bridge_tb.sv
`timescale 1ns/1ps
module fifo_bus_bridge_tb;
   localparam logic [31:0] BASE = 32'hA000_0400;
   localparam int DW = 32, WCW = 9, RCW = 9, DEPTH = 4;

   logic hclk = 1'b0, hresetn = 1'b0;
   logic hsel = 0, hwrite = 0;
   logic [31:0] haddr = 0, hwdata = 0, hrdata;
   logic [1:0] htrans = 0;
   logic [2:0] hsize = 3'd2;
   logic hreadyout, hresp, push_en, pop_en;
   logic [DW-1:0] push_data, pop_data = 0;
   logic st_afull = 0, st_aempty = 0, st_pfull = 0, st_pempty = 0;
   logic st_full, st_empty;
   logic [WCW-1:0] occ_wr = 0;
   logic [RCW-1:0] occ_rd = 0;
   logic flush_all, flush_wr, flush_rd, irq;
   logic [WCW-1:0] pfull_lvl, pfull_hi, pfull_lo;
   logic [RCW-1:0] pempty_lvl, pempty_lo, pempty_hi;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 hclk = ~hclk;

   fifo_bus_bridge #(.BASE_ADDR(BASE), .DW(DW), .WCW(WCW), .RCW(RCW)) u_dut (
      .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
      .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
      .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
      .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
      .pop_data(pop_data), .st_full(st_full), .st_empty(st_empty),
      .st_afull(st_afull), .st_aempty(st_aempty), .st_pfull(st_pfull),
      .st_pempty(st_pempty), .occ_wr(occ_wr), .occ_rd(occ_rd),
      .flush_all(flush_all), .flush_wr(flush_wr), .flush_rd(flush_rd),
      .pfull_lvl(pfull_lvl), .pempty_lvl(pempty_lvl), .pfull_hi(pfull_hi),
      .pempty_lo(pempty_lo), .pfull_lo(pfull_lo), .pempty_hi(pempty_hi),
      .irq(irq)
   );

   // FIFO model: storage with one-cycle read latency
   logic [DW-1:0] mem_q[$];
   int lvl = 0;
   assign st_full  = (lvl == DEPTH);
   assign st_empty = (lvl == 0);
   always @(posedge hclk) begin
      if (push_en) begin mem_q.push_back(push_data); lvl <= lvl + 1; end
      if (pop_en)  begin pop_data <= mem_q.pop_front(); lvl <= lvl - 1; end
   end

   // scoreboard of words expected back from the data port
   logic [31:0] exp_q[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [31:0] off, logic [31:0] data);
      bit to_fifo;
      to_fifo = (off == 0) && (lvl < DEPTH);
      hsel = 1; htrans = 2'b10; hwrite = 1; haddr = BASE + off;
      @(posedge hclk); @(negedge hclk);
      hsel = 0; htrans = 2'b00; hwdata = data;
      #1;
      chk("R3 write no wait", 32'(hreadyout), 32'd1);
      if (off == 0) begin
         chk("R4 push strobe", 32'(push_en), 32'(to_fifo));
         if (to_fifo) begin
            chk("R4 push data", push_data, data);
            exp_q.push_back(data);
         end
      end
      @(posedge hclk); @(negedge hclk);
   endtask

   task automatic bus_read(logic [31:0] off, output logic [31:0] data);
      bit do_pop;
      do_pop = (off == 0) && (lvl > 0);
      hsel = 1; htrans = 2'b10; hwrite = 0; haddr = BASE + off;
      @(posedge hclk); @(negedge hclk);
      hsel = 0; htrans = 2'b00;
      #1;
      chk("R3 read wait", 32'(hreadyout), 32'd0);
      chk("R2 pop strobe", 32'(pop_en), 32'(do_pop));
      @(posedge hclk); @(negedge hclk);
      #1;
      chk("R3 read done", 32'(hreadyout), 32'd1);
      data = hrdata;
      @(posedge hclk); @(negedge hclk);
   endtask

   task automatic pop_check(string req);
      logic [31:0] got, exp;
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 32'd0;
      bus_read(0, got);
      chk(req, got, exp);
   endtask

   initial begin
      repeat (20000) @(posedge hclk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge hclk);
      hresetn = 1;
      @(negedge hclk); #1;
      // reset state
      chk("R3 reset hreadyout", 32'(hreadyout), 32'd1);
      chk("R3 hresp okay", 32'(hresp), 32'd0);
      chk("R8 reset irq", 32'(irq), 32'd0);
      chk("R4 reset push", 32'(push_en), 32'd0);
      chk("R5 reset threshold", 32'(pfull_lvl), 32'd0);
      @(negedge hclk);

      // R4 / R2: simple push then pop, ordering
      bus_write(0, 32'h1111_AAAA);
      bus_write(0, 32'h2222_BBBB);
      bus_write(0, 32'hDEAD_0003);
      pop_check("R2 pop data 1");
      pop_check("R2 pop data 2");
      pop_check("R2 pop data 3");
      // pop while empty returns zero
      pop_check("R2 pop empty zero");

      // R4: fill, overflow blocked, drain
      for (int i = 0; i < DEPTH + 1; i++) bus_write(0, 32'hC0DE_0000 + 32'(i));
      chk("R4 level at full", 32'(lvl), 32'(DEPTH));
      for (int i = 0; i < DEPTH; i++) pop_check("R2 drain after full");
      chk("R2 drained", 32'(lvl), 32'd0);

      // R5: thresholds truncate and zero-extend
      bus_write(32'h04, 32'hFFFF_FFFF);
      bus_write(32'h08, 32'h0000_0123);
      bus_write(32'h0C, 32'h0000_0055);
      bus_write(32'h10, 32'h0000_0066);
      bus_write(32'h14, 32'h0000_0077);
      bus_write(32'h18, 32'hABCD_E1F8);
      bus_read(32'h04, v); chk("R5 pfull_lvl read", v, 32'h1FF);
      chk("R5 pfull_lvl out", 32'(pfull_lvl), 32'h1FF);
      bus_read(32'h08, v); chk("R5 pempty_lvl read", v, 32'h123);
      chk("R5 pfull_hi out", 32'(pfull_hi), 32'h055);
      chk("R5 pempty_lo out", 32'(pempty_lo), 32'h066);
      chk("R5 pfull_lo out", 32'(pfull_lo), 32'h077);
      bus_read(32'h18, v); chk("R5 pempty_hi read", v, 32'h1F8);
      chk("R5 pempty_hi out", 32'(pempty_hi), 32'h1F8);

      // R6: control flush pulses and readback
      bus_write(32'h1C, 32'h0000_000F);
      #1;
      chk("R6 flush pulses", {29'd0, flush_all, flush_wr, flush_rd}, 32'h7);
      @(negedge hclk); #1;
      chk("R6 flush one cycle", {29'd0, flush_all, flush_wr, flush_rd}, 32'h0);
      bus_read(32'h1C, v); chk("R6 control readback", v, 32'h1);
      bus_write(32'h1C, 32'h0000_0004);
      #1;
      chk("R6 flush_wr alone", {29'd0, flush_all, flush_wr, flush_rd}, 32'h2);

      // R7: enables, live status, counts
      bus_write(32'h20, 32'hFFFF_FFFF);
      bus_read(32'h20, v); chk("R7 enable readback", v, 32'h3F);
      bus_write(32'h20, 32'h0);
      st_pfull = 1; st_aempty = 1; occ_wr = 9'd300; occ_rd = 9'd17;
      bus_read(32'h24, v); chk("R7 status order", v, 32'b01_1010); // pfull,aempty,empty
      bus_read(32'h28, v); chk("R7 write count", v, 32'd300);
      bus_read(32'h2C, v); chk("R7 read count", v, 32'd17);
      st_pfull = 0; st_aempty = 0;

      // R8: irq gating (gie currently 0)
      bus_write(32'h20, 32'h0000_0004); // afull only
      st_afull = 1; #1;
      chk("R8 irq global off", 32'(irq), 32'd0);
      bus_write(32'h1C, 32'h1); #1;
      chk("R8 irq on", 32'(irq), 32'd1);
      st_afull = 0; #1;
      chk("R8 irq source gone", 32'(irq), 32'd0);
      st_pfull = 1; #1;
      chk("R8 irq masked source", 32'(irq), 32'd0);
      st_pfull = 0;

      // R9: sticky record, clear on read
      bus_read(32'h30, v); // flush record from earlier activity
      @(negedge hclk);
      st_afull = 1; @(negedge hclk); st_afull = 0; #1;
      bus_read(32'h30, v); chk("R9 record set", v, 32'h04);
      bus_read(32'h30, v); chk("R9 record cleared", v, 32'h00);

      // R10: unused offsets
      bus_write(32'h34, 32'hFFFF_FFFF);
      bus_read(32'h34, v); chk("R10 unused read zero", v, 32'h0);
      bus_read(32'h3C, v); chk("R10 unused 0x3C zero", v, 32'h0);
      bus_read(32'h1C, v); chk("R10 control untouched", v, 32'h1);

      // R1: out-of-window and idle transfers
      bus_write(0, 32'h5A5A_0001); // one word in FIFO
      hsel = 1; htrans = 2'b10; hwrite = 0; haddr = BASE + 32'h40;
      @(posedge hclk); @(negedge hclk); hsel = 0; htrans = 0; #1;
      chk("R1 outside no wait", 32'(hreadyout), 32'd1);
      chk("R1 outside no pop", 32'(pop_en), 32'd0);
      hsel = 1; htrans = 2'b00; hwrite = 0; haddr = BASE;
      @(posedge hclk); @(negedge hclk); hsel = 0; #1;
      chk("R1 idle no pop", 32'(pop_en), 32'd0);
      hsel = 1; htrans = 2'b10; hwrite = 1; haddr = BASE - 32'h400;
      @(posedge hclk); @(negedge hclk); hsel = 0; htrans = 0; hwdata = 32'h1; #1;
      chk("R1 outside no push", 32'(push_en), 32'd0);
      @(negedge hclk);
      chk("R1 level kept", 32'(lvl), 32'd1);
      pop_check("R1 word intact");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule